// File: doc/BRIEF.md
# Frame-Synchronous DAC Sample Stager

This block is the register-mapped front end of a 32-channel, 16-bit streaming DAC. A simple write port carries two kinds of traffic. Sample writes land in per-channel staging registers. Control writes set the hold, update, continuous, configuration and LED registers. A free-running frame timer marks a boundary every 98 clock cycles. At each boundary the block decides, channel by channel, whether the staged code enters the outgoing frame. It then raises a one-cycle frame strobe together with a per-channel publish mask and the latched 16-bit codes for a downstream serializer.

Each channel commits data in one of three ways:
- If it is free-running, it sends on the next frame.
- If it is held, it sends only when an explicit, self-clearing update bit is set. This lets several channels change together on one frame edge.
- If its continuous bit is set, it is refreshed every frame.

A packed group mode writes `2^LOG2_GROUP` consecutive channels in one transfer. Codes are unsigned, and 0x8000 is mid-scale (0 V).

The write port uses a valid/ready handshake. A write is taken in every cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while reset is asserted, so the block never applies back-pressure once running. Frame outputs are plain strobes with no back-pressure: the serializer must take each frame in the strobe cycle.

Top module: `dac_frame_stager`

## Requirements
- R1: While reset is asserted, every latched channel code is 0x8000. `pub_mask`, `frame_stb`, `grp_err`, `cfg_o`, `led_o` and `wr_ready` are all 0. The hold, update and continuous masks start at 0.
- R2: `frame_stb` is high for exactly one cycle every `FRAME_LEN` (98) cycles. The first pulse is seen 98 cycles after reset is released. `pub_mask` is zero whenever `frame_stb` is low.
- R3: A single write (`wr_group`=0) to address N, with N from 0 to 31, stages `wr_data[15:0]` for channel N. If channel N is not held, the next frame strobe sets bit N of `pub_mask` and shows the code on `pub_data[16N+15:16N]`. Channels that are not published keep their previous latched code.
- R4: A held channel is published only at a boundary where its bit in the update mask (address 0x20) is set. The whole update mask clears itself at every boundary, unless a write to 0x20 lands in that same cycle.
- R5: The hold mask (address 0x21) is sampled at each boundary. A boundary decides with the hold value captured at the boundary before it. A hold bit written in the same frame as an update or a sample therefore does not yet hold that channel.
- R6: A channel whose bit is set in the continuous mask (address 0x25) is published every frame, even when no new sample arrived.
- R7: A group write (`wr_group`=1) to an aligned base B stages channel B+k from `wr_data[16k+15:16k]`, for k below `wr_len`. Channels with k at or above `wr_len` are staged as 0. Each 32-bit word holds the even channel in bits 15:0 and the odd channel in bits 31:16.
- R8: A group write whose base has any of its low `LOG2_GROUP` bits set stages nothing and sets the sticky `grp_err` flag. Writing the configuration register with bit 3 set clears the flag.
- R9: The configuration register is at address 0x22. Its bits drive `cfg_o`: bit 0 subsystem reset, bit 1 analog power-down, bit 2 force mid-scale, bit 3 error clear. While bit 2 is set, every boundary publishes all channels at 0x8000, and the staged codes are left untouched.
- R10: A write to address 0x23 sets `led_o` to `wr_data[7:0]`. Writes to any unmapped address (such as 0x24) change no register and no channel.
- R11: `wr_ready` is high in every cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted when high together with `wr_valid` |
| wr_group | input | 1 | 1 selects a packed group write |
| wr_addr | input | 8 | Channel number, group base or control register address |
| wr_len | input | $clog2(2^LOG2_GROUP+1) | Number of channels supplied by a group write |
| wr_data | input | max(32, 16·2^LOG2_GROUP) | Write payload |
| frame_stb | output | 1 | One-cycle frame strobe |
| pub_mask | output | NUM_CH | Channels published in this frame |
| pub_data | output | 16·NUM_CH | Latched code of every channel |
| cfg_o | output | 4 | Configuration register bits |
| led_o | output | 8 | LED byte |
| grp_err | output | 1 | Sticky misaligned group write flag |

## Verification
The bench stages samples on a held channel and checks that nothing leaves until an update is written. It then checks that a second, idle frame publishes nothing. A design with an update bit that does not clear itself would republish forever. A design that ignores hold would send the samples early.

The bench also writes hold, update and a sample in one frame and expects the sample to go out at once. This catches a design that applies the hold mask before the boundary has sampled it.

Group writes are checked with a short length, to catch a design that leaves unsupplied channels stale instead of zero, and with a misaligned base, to catch a design that stages a shifted group or never raises the error flag. Force mid-scale is checked for an all-channel 0x8000 frame, with no stale staged code leaking out after it is released.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  localparam int SAMPLE_W = 16;
  localparam logic [SAMPLE_W-1:0] MIDSCALE = 16'h8000;

  localparam logic [7:0] ADDR_UPDATE = 8'h20;
  localparam logic [7:0] ADDR_HOLD   = 8'h21;
  localparam logic [7:0] ADDR_CFG    = 8'h22;
  localparam logic [7:0] ADDR_LED    = 8'h23;
  localparam logic [7:0] ADDR_CONT   = 8'h25;

  localparam int CFG_W       = 4;
  localparam int CFG_CORE_RST = 0;
  localparam int CFG_ANA_OFF  = 1;
  localparam int CFG_MID      = 2;
  localparam int CFG_ERR_CLR  = 3;
  localparam int LED_W        = 8;
endpackage

// File: rtl/dfs_frame_timer.sv
module dfs_frame_timer #(
  parameter int FRAME_LEN = 98
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R2: boundary never repeats on consecutive cycles
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R2: counter stays inside the frame
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/dfs_write_decoder.sv
module dfs_write_decoder
  import dfs_pkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int LOG2_GROUP = 2,
  parameter int BUS_W      = 64,
  parameter int LEN_W      = 3
) (
  input  logic                       fire,
  input  logic                       group,
  input  logic [7:0]                 addr,
  input  logic [LEN_W-1:0]           len,
  input  logic [BUS_W-1:0]           data,
  output logic [NUM_CH-1:0]          stage_en,
  output logic [NUM_CH*SAMPLE_W-1:0] stage_val,
  output logic                       upd_we,
  output logic                       hold_we,
  output logic                       cfg_we,
  output logic                       led_we,
  output logic                       cont_we,
  output logic                       misalign
);
  localparam int GROUP = 1 << LOG2_GROUP;
  localparam logic [7:0] ALIGN    = 8'(GROUP - 1);
  localparam logic [7:0] CH_LIMIT = 8'(NUM_CH);

  logic in_range, aligned, grp_ok, one_ok, ctl;

  assign in_range = (addr < CH_LIMIT);
  assign aligned  = ((addr & ALIGN) == 8'd0);
  assign grp_ok   = fire & group & in_range & aligned;
  assign one_ok   = fire & ~group & in_range;
  assign misalign = fire & group & in_range & ~aligned;
  assign ctl      = fire & ~group;

  assign upd_we  = ctl & (addr == ADDR_UPDATE);
  assign hold_we = ctl & (addr == ADDR_HOLD);
  assign cfg_we  = ctl & (addr == ADDR_CFG);
  assign led_we  = ctl & (addr == ADDR_LED);
  assign cont_we = ctl & (addr == ADDR_CONT);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [7:0] C8 = 8'(c);
    localparam int K = c % GROUP;
    localparam logic [LEN_W-1:0] KL = LEN_W'(K);
    logic hit_one, hit_grp;
    assign hit_one = one_ok & (addr == C8);
    assign hit_grp = grp_ok & ((addr >> LOG2_GROUP) == (C8 >> LOG2_GROUP));
    assign stage_en[c] = hit_one | hit_grp;
    always_comb begin
      if (hit_grp)
        stage_val[c*SAMPLE_W +: SAMPLE_W] = (len > KL) ? data[K*SAMPLE_W +: SAMPLE_W] : '0;
      else
        stage_val[c*SAMPLE_W +: SAMPLE_W] = data[SAMPLE_W-1:0];
    end
  end
endmodule

// File: rtl/dfs_channel_lane.sv
module dfs_channel_lane
  import dfs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                stage_en,
  input  logic [SAMPLE_W-1:0] stage_val,
  input  logic                held,
  input  logic                upd,
  input  logic                cont,
  input  logic                force_mid,
  output logic                pub,
  output logic [SAMPLE_W-1:0] out_val
);
  logic [SAMPLE_W-1:0] staged;
  logic                dirty;
  logic                commit;

  assign commit = cont | (held ? upd : dirty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged <= MIDSCALE;
      dirty  <= 1'b0;
    end else begin
      if (stage_en) staged <= stage_val;
      if (stage_en) dirty <= 1'b1;
      else if (tick && commit && !force_mid) dirty <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_val <= MIDSCALE;
      pub     <= 1'b0;
    end else if (tick) begin
      if (force_mid) begin
        out_val <= MIDSCALE;
        pub     <= 1'b1;
      end else if (commit) begin
        out_val <= staged;
        pub     <= 1'b1;
      end else begin
        pub <= 1'b0;
      end
    end else begin
      pub <= 1'b0;
    end
  end

  // R4: held channel without update, continuous or force stays silent
  p_held_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && held && !upd && !cont && !force_mid) |=> !pub);
  // R9: force mid-scale publishes 0x8000
  p_force_mid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && force_mid) |=> (pub && out_val == MIDSCALE));
endmodule

// File: rtl/dac_frame_stager.sv
module dac_frame_stager
  import dfs_pkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int LOG2_GROUP = 2,
  parameter int FRAME_LEN  = 98,
  localparam int GROUP = 1 << LOG2_GROUP,
  localparam int GRP_W = SAMPLE_W * GROUP,
  localparam int BUS_W = (GRP_W > 32) ? GRP_W : 32,
  localparam int LEN_W = $clog2(GROUP + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic                       wr_group,
  input  logic [7:0]                 wr_addr,
  input  logic [LEN_W-1:0]           wr_len,
  input  logic [BUS_W-1:0]           wr_data,
  output logic                       frame_stb,
  output logic [NUM_CH-1:0]          pub_mask,
  output logic [NUM_CH*SAMPLE_W-1:0] pub_data,
  output logic [CFG_W-1:0]           cfg_o,
  output logic [LED_W-1:0]           led_o,
  output logic                       grp_err
);
  logic tick, fire;
  logic [NUM_CH-1:0] stage_en;
  logic [NUM_CH*SAMPLE_W-1:0] stage_val;
  logic upd_we, hold_we, cfg_we, led_we, cont_we, misalign;
  logic [NUM_CH-1:0] hold_reg, hold_snap, upd_reg, cont_reg;

  assign fire = wr_valid & wr_ready;

  dfs_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  dfs_write_decoder #(
    .NUM_CH(NUM_CH), .LOG2_GROUP(LOG2_GROUP), .BUS_W(BUS_W), .LEN_W(LEN_W)
  ) u_dec (
    .fire(fire), .group(wr_group), .addr(wr_addr), .len(wr_len), .data(wr_data),
    .stage_en(stage_en), .stage_val(stage_val),
    .upd_we(upd_we), .hold_we(hold_we), .cfg_we(cfg_we), .led_we(led_we),
    .cont_we(cont_we), .misalign(misalign));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ready  <= 1'b0;
      frame_stb <= 1'b0;
      hold_reg  <= '0;
      hold_snap <= '0;
      upd_reg   <= '0;
      cont_reg  <= '0;
      cfg_o     <= '0;
      led_o     <= '0;
      grp_err   <= 1'b0;
    end else begin
      wr_ready  <= 1'b1;
      frame_stb <= tick;
      if (hold_we) hold_reg <= wr_data[NUM_CH-1:0];
      if (tick) hold_snap <= hold_reg;
      if (upd_we) upd_reg <= wr_data[NUM_CH-1:0];
      else if (tick) upd_reg <= '0;
      if (cont_we) cont_reg <= wr_data[NUM_CH-1:0];
      if (cfg_we) cfg_o <= wr_data[CFG_W-1:0];
      if (led_we) led_o <= wr_data[LED_W-1:0];
      if (misalign) grp_err <= 1'b1;
      else if (cfg_we && wr_data[CFG_ERR_CLR]) grp_err <= 1'b0;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    dfs_channel_lane u_lane (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .stage_en(stage_en[c]), .stage_val(stage_val[c*SAMPLE_W +: SAMPLE_W]),
      .held(hold_snap[c]), .upd(upd_reg[c]), .cont(cont_reg[c]),
      .force_mid(cfg_o[CFG_MID]),
      .pub(pub_mask[c]), .out_val(pub_data[c*SAMPLE_W +: SAMPLE_W]));
  end

  // R2: no channel is published outside the frame strobe
  p_mask_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |-> (pub_mask == '0));
  // R4: update mask is consumed at the boundary
  p_upd_selfclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !upd_we) |=> (upd_reg == '0));
  // R8: error flag stays set until a configuration write
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_err && !cfg_we) |=> grp_err);
  // R11: port accepts writes once running
  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wr_ready);
endmodule

// File: tb/dac_frame_stager_test.sv
`timescale 1ns/1ps
module dac_frame_stager_test;
  localparam int NCH = 32;
  localparam int LW  = 3;
  localparam int BW  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic wr_group = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [LW-1:0] wr_len = '0;
  logic [BW-1:0] wr_data = '0;
  logic frame_stb;
  logic [NCH-1:0] pub_mask;
  logic [NCH*16-1:0] pub_data;
  logic [3:0] cfg_o;
  logic [7:0] led_o;
  logic grp_err;

  int checks = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  dac_frame_stager uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_group(wr_group), .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data),
    .frame_stb(frame_stb), .pub_mask(pub_mask), .pub_data(pub_data),
    .cfg_o(cfg_o), .led_o(led_o), .grp_err(grp_err));

  // addr, data, expected mask, checked channel, expected code
  localparam logic [92:0] VEC [0:12] = '{
    {8'h03, 32'h0000_1234, 32'h0000_0008, 5'd3,  16'h1234}, // R3
    {8'h1F, 32'h0000_FFFF, 32'h8000_0000, 5'd31, 16'hFFFF}, // R3
    {8'h21, 32'h0000_0003, 32'h0000_0000, 5'd3,  16'h1234}, // R5
    {8'h00, 32'h0000_0AAA, 32'h0000_0000, 5'd0,  16'h8000}, // R4
    {8'h01, 32'h0000_0BBB, 32'h0000_0000, 5'd1,  16'h8000}, // R4
    {8'h20, 32'h0000_0003, 32'h0000_0003, 5'd0,  16'h0AAA}, // R4
    {8'h20, 32'h0000_0003, 32'h0000_0003, 5'd1,  16'h0BBB}, // R4
    {8'h23, 32'h0000_005A, 32'h0000_0000, 5'd1,  16'h0BBB}, // R10
    {8'h25, 32'h0000_0010, 32'h0000_0010, 5'd4,  16'h8000}, // R6
    {8'h25, 32'h0000_0000, 32'h0000_0000, 5'd4,  16'h8000}, // R6
    {8'h21, 32'h0000_0000, 32'h0000_0000, 5'd0,  16'h0AAA}, // R5
    {8'h00, 32'h0000_0CCC, 32'h0000_0001, 5'd0,  16'h0CCC}, // R3
    {8'h24, 32'hFFFF_FFFF, 32'h0000_0000, 5'd0,  16'h0CCC}  // R10
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic grp, input logic [7:0] a,
                           input logic [LW-1:0] n, input logic [BW-1:0] d);
    wr_valid = 1'b1; wr_group = grp; wr_addr = a; wr_len = n; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_group = 1'b0; wr_data = '0;
  endtask

  task automatic wait_frame();
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!frame_stb && k < 200);
    if (!frame_stb) check("R2 strobe present", 64'd0, 64'd1);
  endtask

  function automatic logic [15:0] ch(input int c);
    return pub_data[c*16 +: 16];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mask", 64'(pub_mask), 64'd0);
    check("R1 strobe", 64'(frame_stb), 64'd0);
    check("R1 ch0", 64'(ch(0)), 64'h8000);
    check("R1 ch31", 64'(ch(31)), 64'h8000);
    check("R1 err", 64'(grp_err), 64'd0);
    check("R1 cfg", 64'(cfg_o), 64'd0);
    check("R1 led", 64'(led_o), 64'd0);
    check("R1 ready", 64'(wr_ready), 64'd0);
    rst_n = 1'b1;

    // R2 first strobe after 98 cycles, then period 98
    begin
      int k = 0;
      do begin @(negedge clk); k++; end while (!frame_stb && k < 300);
      check("R2 first strobe", 64'(k), 64'd98);
      check("R11 ready", 64'(wr_ready), 64'd1);
      k = 0;
      do begin @(negedge clk); k++; end while (!frame_stb && k < 300);
      check("R2 period", 64'(k), 64'd98);
      @(negedge clk);
      check("R2 single cycle", 64'(frame_stb), 64'd0);
    end

    // vector table
    for (int i = 0; i < 13; i++) begin
      logic [92:0] v;
      v = VEC[i];
      repeat (2) @(negedge clk);
      bus_write(1'b0, v[92:85], '0, 64'(v[84:53]));
      wait_frame();
      check($sformatf("R3/R4/R5/R6/R10 vec%0d mask", i), 64'(pub_mask), 64'(v[52:21]));
      check($sformatf("R3/R4/R5/R6/R10 vec%0d code", i), 64'(ch(int'(v[20:16]))), 64'(v[15:0]));
    end

    // R10 led and unmapped address
    bus_write(1'b0, 8'h23, '0, 64'h0000_00A5);
    check("R10 led", 64'(led_o), 64'hA5);
    bus_write(1'b0, 8'h24, '0, 64'hFFFF_FFFF);
    check("R10 unmapped led", 64'(led_o), 64'hA5);
    check("R10 unmapped cfg", 64'(cfg_o), 64'd0);
    wait_frame();

    // R7 group write, three of four supplied
    repeat (2) @(negedge clk);
    bus_write(1'b1, 8'd8, 3'd3, 64'h4444_3333_2222_1111);
    wait_frame();
    check("R7 mask", 64'(pub_mask), 64'h0000_0F00);
    check("R7 ch8", 64'(ch(8)), 64'h1111);
    check("R7 ch9", 64'(ch(9)), 64'h2222);
    check("R7 ch10", 64'(ch(10)), 64'h3333);
    check("R7 ch11 cleared", 64'(ch(11)), 64'h0000);

    // R8 misaligned group write
    repeat (2) @(negedge clk);
    bus_write(1'b1, 8'd6, 3'd4, 64'h9999_9999_9999_9999);
    check("R8 err set", 64'(grp_err), 64'd1);
    wait_frame();
    check("R8 nothing staged", 64'(pub_mask), 64'd0);
    check("R8 ch6", 64'(ch(6)), 64'h8000);
    repeat (2) @(negedge clk);
    bus_write(1'b0, 8'h22, '0, 64'h8);
    check("R8 err cleared", 64'(grp_err), 64'd0);
    check("R9 cfg bits", 64'(cfg_o), 64'h8);

    // R9 force mid-scale
    bus_write(1'b0, 8'h22, '0, 64'h4);
    wait_frame();
    check("R9 all published", 64'(pub_mask), 64'hFFFF_FFFF);
    check("R9 ch0 mid", 64'(ch(0)), 64'h8000);
    check("R9 ch9 mid", 64'(ch(9)), 64'h8000);
    repeat (2) @(negedge clk);
    bus_write(1'b0, 8'h22, '0, 64'h0);
    wait_frame();
    check("R9 released mask", 64'(pub_mask), 64'd0);
    check("R9 released ch0", 64'(ch(0)), 64'h8000);

    // R5 hold and update written in the same frame as a sample
    repeat (2) @(negedge clk);
    bus_write(1'b0, 8'h21, '0, 64'h4);
    bus_write(1'b0, 8'h20, '0, 64'h4);
    bus_write(1'b0, 8'h02, '0, 64'h2020);
    wait_frame();
    check("R5 old hold used", 64'(pub_mask), 64'h4);
    check("R5 ch2", 64'(ch(2)), 64'h2020);
    repeat (2) @(negedge clk);
    bus_write(1'b0, 8'h02, '0, 64'h2121);
    wait_frame();
    check("R4 held quiet", 64'(pub_mask), 64'd0);
    check("R4 held code", 64'(ch(2)), 64'h2020);
    repeat (2) @(negedge clk);
    bus_write(1'b0, 8'h20, '0, 64'h4);
    wait_frame();
    check("R4 update", 64'(pub_mask), 64'h4);
    check("R4 update code", 64'(ch(2)), 64'h2121);
    wait_frame();
    check("R4 self clear", 64'(pub_mask), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule